// File: doc/BRIEF.md
# Half-Duplex Serial Character Receiver with Direction-Aware Break Handling

This block takes characters from one shared serial data line and samples one bit on every rising edge of its clock, which is the recovered bit clock. A character is a low start bit, a data byte sent least-significant bit first, an even parity bit and two stop bits. The block checks parity and framing. A byte that passes both checks goes to the downstream controller as a one-cycle valid strobe with the data beside it.

The block also keeps track of the link direction. A BREAK is a whole character time sampled low. In receive direction a BREAK is reported as a BREAK event. In transmit direction the same pattern is reported as a collision, and the direction drops to receive in the same step. Because of this, the second of two BREAKs with line-high time between them is always reported as a BREAK. After any error or BREAK, the receiver waits for the line to return high before it will accept a new start bit.

Top module: `hdx_frame_rx`

## Requirements
- R1: When idle with the line high, a low sample is the start bit. The next 8 samples are data bits (first sample is bit 0), then 1 parity sample, then 2 stop samples. Every status output is a single-cycle pulse that is high in the cycle after the edge that samples the second stop bit.
- R2: Parity is even: the parity sample must equal the XOR of the 8 data bits. A mismatch gives a `parityErr` pulse and no `dataValid`.
- R3: If either stop sample or both is low, and the character is not a BREAK, the result is a `frameErr` pulse and no `dataValid`.
- R4: `dataValid` pulses, with `dataOut` equal to the received byte, only when parity matches and both stops are high. It is never high together with any error, break or collision output.
- R5: With `dirTx` low, a character whose 12 samples are all low gives a `breakSeen` pulse, with no `parityErr` and no `frameErr`.
- R6: With `dirTx` high, an all-low character gives a `collision` pulse and no `breakSeen`. `dirTx` reads low in that same cycle.
- R7: Two all-low characters separated by at least one high bit always end with a `breakSeen` pulse for the second one, whichever direction applied before the first.
- R8: After an error or a BREAK that ends on a low sample, a line that stays low starts no new character. The first start bit is accepted only after the line has been high.
- R9: After reset `dirTx` is 0 and every pulse output is 0. A `setTx` pulse makes `dirTx` read 1 from the following cycle.
- R10: A line held high produces no pulse on any status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line sample per rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Shared serial data line as seen by the receiver |
| setTx | input | 1 | Request from the controller to enter transmit direction |
| dirTx | output | 1 | Current link direction, 1 for transmit |
| dataValid | output | 1 | Pulse: a good byte is on dataOut |
| dataOut | output | 8 | Last received byte |
| parityErr | output | 1 | Pulse: parity mismatch |
| frameErr | output | 1 | Pulse: a stop bit sampled low |
| breakSeen | output | 1 | Pulse: BREAK received in receive direction |
| collision | output | 1 | Pulse: BREAK seen in transmit direction |

## Verification
The bench uses the defaults: 8 data bits and 2 stop bits. With a byte this narrow it can sweep all 256 values, both with correct parity and with parity inverted, and run every stop-bit error combination over a spread of bytes. The expected parity is computed as the XOR of the byte. The small frame also makes it cheap to run the BREAK sequences in both starting directions and a long low hold after a BREAK, and to check every cycle of those.

// File: rtl/hdx_rx_pkg.sv
package hdx_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } rxState_t;

  typedef struct packed {
    logic clrAcc;
    logic shiftEn;
    logic capParity;
    logic stopEn;
    logic finish;
  } rxStrobes_t;

endpackage

// File: rtl/hdx_rx_datapath.sv
module hdx_rx_datapath #(
  parameter int DATA_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lineIn,
  input  hdx_rx_pkg::rxStrobes_t   stb,
  output logic [DATA_BITS-1:0]     heldData,
  output logic                     parityOk,
  output logic                     stopsOk,
  output logic                     allLow
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 stopAcc;
  logic                 lowAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      stopAcc  <= 1'b1;
      lowAcc   <= 1'b1;
      heldData <= '0;
    end else begin
      if (stb.clrAcc) begin
        stopAcc <= 1'b1;
        lowAcc  <= 1'b1;
      end
      if (stb.shiftEn) begin
        shiftReg <= {lineIn, shiftReg[DATA_BITS-1:1]};
        lowAcc   <= lowAcc & ~lineIn;
      end
      if (stb.capParity) begin
        parBit <= lineIn;
        lowAcc <= lowAcc & ~lineIn;
      end
      if (stb.stopEn) begin
        stopAcc <= stopAcc & lineIn;
        lowAcc  <= lowAcc & ~lineIn;
      end
      if (stb.finish) heldData <= shiftReg;
    end
  end

  // Decision inputs for the final stop edge include the sample taken there.
  assign parityOk = ((^shiftReg) == parBit);
  assign stopsOk  = stopAcc & lineIn;
  assign allLow   = lowAcc & ~lineIn;

  a_r1_held_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable(heldData));

endmodule

// File: rtl/hdx_rx_control.sv
module hdx_rx_control #(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lineIn,
  input  logic                     setTx,
  input  logic                     parityOk,
  input  logic                     stopsOk,
  input  logic                     allLow,
  output hdx_rx_pkg::rxStrobes_t   stb,
  output logic                     dirTx,
  output logic                     dataValid,
  output logic                     parityErr,
  output logic                     frameErr,
  output logic                     breakSeen,
  output logic                     collision
);
  import hdx_rx_pkg::*;

  localparam int MAXCNT = (DATA_BITS > STOP_BITS) ? DATA_BITS : STOP_BITS;
  localparam int CW     = $clog2(MAXCNT + 1);

  rxState_t        state, stateNx;
  logic [CW-1:0]   cnt, cntNx;
  logic            isBreak;

  always_comb begin
    stateNx = state;
    cntNx   = cnt;
    stb     = '0;
    unique case (state)
      S_IDLE: if (!lineIn) begin
        stb.clrAcc = 1'b1;
        stateNx    = S_DATA;
        cntNx      = '0;
      end
      S_DATA: begin
        stb.shiftEn = 1'b1;
        if (cnt == CW'(DATA_BITS - 1)) begin
          stateNx = S_PAR;
          cntNx   = '0;
        end else begin
          cntNx = cnt + 1'b1;
        end
      end
      S_PAR: begin
        stb.capParity = 1'b1;
        stateNx       = S_STOP;
      end
      S_STOP: begin
        stb.stopEn = 1'b1;
        if (cnt == CW'(STOP_BITS - 1)) begin
          stb.finish = 1'b1;
          stateNx    = lineIn ? S_IDLE : S_WAITHI;
          cntNx      = '0;
        end else begin
          cntNx = cnt + 1'b1;
        end
      end
      S_WAITHI: if (lineIn) stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  assign isBreak = stb.finish & allLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      dirTx     <= 1'b0;
      dataValid <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakSeen <= 1'b0;
      collision <= 1'b0;
    end else begin
      state     <= stateNx;
      cnt       <= cntNx;
      dataValid <= stb.finish & ~allLow & parityOk & stopsOk;
      parityErr <= stb.finish & ~allLow & ~parityOk;
      frameErr  <= stb.finish & ~allLow & ~stopsOk;
      breakSeen <= isBreak & ~dirTx;
      collision <= isBreak & dirTx;
      if (isBreak && dirTx) dirTx <= 1'b0;
      else if (setTx)       dirTx <= 1'b1;
    end
  end

  a_r4_valid_alone: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !(parityErr || frameErr || breakSeen || collision));

  a_r6_collision_rx: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> (!dirTx && $past(dirTx)));

  a_r5_break_rx_only: assert property (@(posedge clk) disable iff (!rstN)
    breakSeen |-> (!$past(dirTx) && !parityErr && !frameErr));

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid || breakSeen || collision) |=> !(dataValid || breakSeen || collision));

  a_r8_wait_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITHI && !lineIn) |=> (state == S_WAITHI));

endmodule

// File: rtl/hdx_frame_rx.sv
module hdx_frame_rx #(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  logic                 setTx,
  output logic                 dirTx,
  output logic                 dataValid,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 breakSeen,
  output logic                 collision
);

  hdx_rx_pkg::rxStrobes_t stb;
  logic parityOk, stopsOk, allLow;

  hdx_rx_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .stb(stb),
    .heldData(dataOut), .parityOk(parityOk), .stopsOk(stopsOk), .allLow(allLow)
  );

  hdx_rx_control #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .setTx(setTx),
    .parityOk(parityOk), .stopsOk(stopsOk), .allLow(allLow), .stb(stb),
    .dirTx(dirTx), .dataValid(dataValid), .parityErr(parityErr),
    .frameErr(frameErr), .breakSeen(breakSeen), .collision(collision)
  );

endmodule

// File: tb/tb_hdx_frame_rx.sv
module tb_hdx_frame_rx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b1;
  logic setTx = 1'b0;
  logic dirTx, dataValid, parityErr, frameErr, breakSeen, collision;
  logic [7:0] dataOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hdx_frame_rx dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .setTx(setTx), .dirTx(dirTx),
    .dataValid(dataValid), .dataOut(dataOut), .parityErr(parityErr),
    .frameErr(frameErr), .breakSeen(breakSeen), .collision(collision)
  );

  // status vector: {dataValid, parityErr, frameErr, breakSeen, collision, dirTx}
  task automatic check(input string req, input logic [5:0] expSt,
                       input logic [7:0] expData);
    logic [5:0] act;
    act = {dataValid, parityErr, frameErr, breakSeen, collision, dirTx};
    checks++;
    if (act !== expSt || (expSt[5] && dataOut !== expData)) begin
      fails++;
      $display("FAIL %s: status=%b data=%02h expected status=%b data=%02h",
               req, act, dataOut, expSt, expData);
    end
  endtask

  task automatic driveBit(input logic b);
    @(negedge clk);
    lineIn = b;
  endtask

  // Drives a full character; returns at the negedge where status is visible.
  task automatic sendChar(input logic [7:0] d, input logic par,
                          input logic s1, input logic s2);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    driveBit(par);
    driveBit(s1);
    driveBit(s2);
    @(negedge clk);
  endtask

  task automatic idleGap(input int n);
    lineIn = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: status=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] sb;
    repeat (3) @(negedge clk);
    check("R9 reset", 6'b000000, 8'h00);
    rstN = 1'b1;

    // R10: idle high line yields nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0) check("R10 idle", 6'b000000, 8'h00);
    end

    // R1 R4: all bytes with correct even parity
    for (int v = 0; v < 256; v++) begin
      sendChar(v[7:0], ^v[7:0], 1'b1, 1'b1);
      check("R1 R4 good byte", 6'b100000, v[7:0]);
      idleGap(1);
      check("R1 pulse ends", 6'b000000, 8'h00);
    end

    // R2: inverted parity over all bytes
    for (int v = 0; v < 256; v++) begin
      sendChar(v[7:0], ~(^v[7:0]), 1'b1, 1'b1);
      check("R2 parity error", 6'b010000, 8'h00);
      idleGap(1);
    end

    // R3: stop-bit error combinations (wait high between)
    for (int v = 1; v < 256; v += 17) begin
      for (int sp = 0; sp < 3; sp++) begin
        sendChar(v[7:0], ^v[7:0], sp[0], sp[1]);
        check("R3 frame error", 6'b001000, 8'h00);
        idleGap(2);
      end
    end

    // R5: BREAK in receive direction
    sendChar(8'h00, 1'b0, 1'b0, 1'b0);
    check("R5 break rx", 6'b000100, 8'h00);
    // R8: keep line low; no new character may start
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R8 hold low", 6'b000000, 8'h00);
    end
    idleGap(1);
    sendChar(8'hA5, ^8'hA5, 1'b1, 1'b1);
    check("R8 resume after high", 6'b100000, 8'hA5);
    idleGap(2);

    // R8 after frame error ending low
    sendChar(8'h3C, ^8'h3C, 1'b1, 1'b0);
    check("R8 frame error", 6'b001000, 8'h00);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      check("R8 hold low fe", 6'b000000, 8'h00);
    end
    idleGap(1);
    sendChar(8'h81, ^8'h81, 1'b1, 1'b1);
    check("R8 resume fe", 6'b100000, 8'h81);
    idleGap(2);

    // R9: enter transmit direction
    setTx = 1'b1;
    @(negedge clk);
    setTx = 1'b0;
    check("R9 setTx", 6'b000001, 8'h00);

    // R6 R7: BREAK in transmit -> collision, second BREAK -> break
    sendChar(8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 collision", 6'b000010, 8'h00);
    idleGap(1);
    sendChar(8'h00, 1'b0, 1'b0, 1'b0);
    check("R7 second break tx start", 6'b000100, 8'h00);
    idleGap(2);

    // R7 starting in receive
    sendChar(8'h00, 1'b0, 1'b0, 1'b0);
    check("R7 first break rx start", 6'b000100, 8'h00);
    idleGap(1);
    sendChar(8'h00, 1'b0, 1'b0, 1'b0);
    check("R7 second break rx start", 6'b000100, 8'h00);
    idleGap(2);

    // R5: an all-zero byte with a high stop is not a break
    sendChar(8'h00, 1'b0, 1'b1, 1'b0);
    check("R5 near break is frame error", 6'b001000, 8'h00);
    idleGap(2);

    // R2 R4 in transmit direction: good byte still delivered
    setTx = 1'b1;
    @(negedge clk);
    setTx = 1'b0;
    sb = 8'h7E;
    sendChar(sb, ^sb, 1'b1, 1'b1);
    check("R4 good byte tx dir", 6'b100001, sb);
    idleGap(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule